// File: doc/BRIEF.md
# Pipelined Fixed-Point Divide and Square-Root Unit

This block is a fully pipelined arithmetic unit for unsigned fixed-point numbers. Each clock cycle it takes a wide dividend, a shared operand (the divisor or the radicand) and a two-bit operation code. After a fixed number of cycles it returns a quotient or root and a remainder. Three operations share one datapath: divide with remainder, square root with remainder, and reciprocal square root with remainder. There is no handshake and no stall. A new operation may enter on every cycle, and operations of different kinds may be in flight together.

The datapath has a setup stage, a row of calculate stages and a final stage, and every stage ends in a register. The setup stage loads a target value that depends on the operation. Each calculate stage then fixes `RADIX_LOG2` result bits, starting from the most significant, with restoring trial subtraction: for each trial bit it works out how much the chosen quantity (Q·D, Q² or Q²·R) would grow, and subtracts that amount from the running remainder if it fits. The final stage trims the result and scales the remainder. Three cases have no defined result: a zero divisor, a zero radicand for the reciprocal root, and any true result of `2^DATA_W` or more.

Top module: `dsq_pipe`

## Requirements
- R1: With op code 0 (divide), the quotient is floor(N/D) for dividend N and operand D, and the remainder output is (N mod D) shifted left by `FRAC_W` bits.
- R2: With op code 1 (square root), the operand R holds `FRAC_W` fraction bits. The root is the largest Q with Q² ≤ R·2^FRAC_W, and the remainder output is (R·2^FRAC_W − Q²) shifted left by `FRAC_W`. The dividend input is ignored.
- R3: With op code 2 (reciprocal square root), the root is the largest Q with Q²·R ≤ 2^(3·FRAC_W), and the remainder output is 2^(3·FRAC_W) − Q²·R, unshifted. The dividend input is ignored.
- R4: A result appears on the outputs exactly ceil((DATA_W+FRAC_W)/RADIX_LOG2) + 2 cycles after its inputs are sampled (14 with the defaults). Each calculate stage only sets bits inside its own `RADIX_LOG2`-bit window.
- R5: The operation code travels with its operands through every stage. Back-to-back inputs that use different op codes each give the result of their own operation.
- R6: Reset clears every pipeline register, so the quotient and remainder outputs read zero while reset is held.
- R7: Boundary operands give exact results: the largest quotient 255 (4095/16), a zero dividend, a zero and the largest radicand for the square root, and radicands 1 and 255 for the reciprocal root.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 2 | Operation code: 0 divide, 1 square root, 2 reciprocal square root |
| dividend_i | input | DATA_W+FRAC_W | Dividend; used only by divide |
| operand_i | input | DATA_W | Divisor or radicand, unsigned fixed point with FRAC_W fraction bits |
| quotient_o | output | DATA_W | Quotient or root |
| remainder_o | output | 2*DATA_W+2*FRAC_W | Remainder, scaled as the operation requires |

## Verification
The bench streams inputs with mixed operation codes on consecutive cycles. If the op code were lost or shared between stages, one operation would be computed with another's recurrence and the roots would come out wrong. The sweeps check the remainder scaling of each operation: a design that shifts the reciprocal remainder, or fails to shift the divide remainder, is off by a factor of 16. Boundary cases cover the widest quotient and the extreme radicands, where an off-by-one in the trial comparison or a truncated remainder register shows up first. An idle-filled flush and a reset in the middle of a stream check the exact latency and the zero reset state.

// File: rtl/dsq_pkg.sv
`timescale 1ns/1ps
package dsq_pkg;
    typedef enum logic [1:0] {
        OP_DIV   = 2'd0,
        OP_SQRT  = 2'd1,
        OP_RSQRT = 2'd2
    } dsq_op_e;
endpackage

// File: rtl/dsq_setup.sv
`timescale 1ns/1ps
module dsq_setup
    import dsq_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int FRAC_W     = 4,
    parameter int RADIX_LOG2 = 1,
    localparam int STAGES    = (DATA_W + FRAC_W + RADIX_LOG2 - 1) / RADIX_LOG2,
    localparam int QW        = STAGES * RADIX_LOG2,
    localparam int IW        = 2 * QW + DATA_W + 2,
    localparam int PW        = 2 + QW + IW + DATA_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               op_i,
    input  logic [DATA_W+FRAC_W-1:0] dividend_i,
    input  logic [DATA_W-1:0]        operand_i,
    output logic [PW-1:0]            stg_o
);
    typedef struct packed {
        dsq_op_e           op;
        logic [QW-1:0]     quo;
        logic [IW-1:0]     rem;
        logic [DATA_W-1:0] opd;
    } stage_t;

    stage_t  stg_d, stg_q;
    dsq_op_e op_e;

    assign op_e = dsq_op_e'(op_i);

    // Load the target that each recurrence subtracts its growth from.
    always_comb begin
        stg_d     = '0;
        stg_d.op  = op_e;
        stg_d.opd = operand_i;
        case (op_e)
            OP_SQRT:  stg_d.rem = IW'(operand_i) << FRAC_W;
            OP_RSQRT: stg_d.rem = IW'(1) << (3 * FRAC_W);
            default:  stg_d.rem = IW'(dividend_i);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign stg_o = stg_q;
endmodule

// File: rtl/dsq_calc.sv
`timescale 1ns/1ps
module dsq_calc
    import dsq_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int FRAC_W     = 4,
    parameter int RADIX_LOG2 = 1,
    parameter int STAGE      = 0,
    localparam int STAGES    = (DATA_W + FRAC_W + RADIX_LOG2 - 1) / RADIX_LOG2,
    localparam int QW        = STAGES * RADIX_LOG2,
    localparam int IW        = 2 * QW + DATA_W + 2,
    localparam int PW        = 2 + QW + IW + DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] stg_i,
    output logic [PW-1:0] stg_o
);
    typedef struct packed {
        dsq_op_e           op;
        logic [QW-1:0]     quo;
        logic [IW-1:0]     rem;
        logic [DATA_W-1:0] opd;
    } stage_t;

    stage_t         in_s, stg_d, stg_q;
    int             k;
    logic [IW-1:0]  step;
    logic [IW-1:0]  delta;

    assign in_s = stg_i;

    // Retire RADIX_LOG2 bits, most significant first, by restoring trial subtraction.
    always_comb begin
        stg_d = in_s;
        k     = 0;
        step  = '0;
        delta = '0;
        for (int j = 0; j < RADIX_LOG2; j++) begin
            k    = QW - 1 - STAGE * RADIX_LOG2 - j;
            step = (IW'(stg_d.quo) << (k + 1)) + (IW'(1) << (2 * k));
            case (stg_d.op)
                OP_SQRT:  delta = step;
                OP_RSQRT: delta = step * IW'(stg_d.opd);
                default:  delta = IW'(stg_d.opd) << k;
            endcase
            if (delta <= stg_d.rem) begin
                stg_d.rem    = stg_d.rem - delta;
                stg_d.quo[k] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign stg_o = stg_q;

    // The running remainder can only shrink as result bits are fixed.
    p_rem_nonincreasing_r1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (stg_q.rem <= $past(in_s.rem)));

    // The operation code passes through the stage unchanged.
    p_op_carried_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (stg_q.op == $past(in_s.op)));

    generate
        if (STAGE > 0) begin : g_prefix
            localparam logic [QW:0] HI_ONE = (QW + 1)'(1) << (QW - STAGE * RADIX_LOG2);
            localparam logic [QW-1:0] KEEP = ~QW'(HI_ONE - 1'b1);
            // Bits fixed by earlier stages are never changed here.
            p_prefix_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> ((stg_q.quo & KEEP) == ($past(in_s.quo) & KEEP)));
        end
    endgenerate
endmodule

// File: rtl/dsq_final.sv
`timescale 1ns/1ps
module dsq_final
    import dsq_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int FRAC_W     = 4,
    parameter int RADIX_LOG2 = 1,
    localparam int STAGES    = (DATA_W + FRAC_W + RADIX_LOG2 - 1) / RADIX_LOG2,
    localparam int QW        = STAGES * RADIX_LOG2,
    localparam int IW        = 2 * QW + DATA_W + 2,
    localparam int PW        = 2 + QW + IW + DATA_W,
    localparam int RW        = 2 * DATA_W + 2 * FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PW-1:0]     stg_i,
    output logic [DATA_W-1:0] quotient_o,
    output logic [RW-1:0]     remainder_o
);
    typedef struct packed {
        dsq_op_e           op;
        logic [QW-1:0]     quo;
        logic [IW-1:0]     rem;
        logic [DATA_W-1:0] opd;
    } stage_t;

    typedef struct packed {
        logic [DATA_W-1:0] quo;
        logic [RW-1:0]     rem;
    } result_t;

    stage_t  in_s;
    result_t res_d, res_q;
    logic    unused_bits;

    assign in_s        = stg_i;
    assign unused_bits = ^{in_s.opd, in_s.quo[QW-1:DATA_W]};

    always_comb begin
        res_d.quo = in_s.quo[DATA_W-1:0];
        if (in_s.op == OP_RSQRT) res_d.rem = RW'(in_s.rem);
        else                     res_d.rem = RW'(in_s.rem << FRAC_W);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign quotient_o  = res_q.quo;
    assign remainder_o = res_q.rem;

    generate
        if (FRAC_W > 0) begin : g_scale_chk
            // Divide and square-root remainders leave the fraction field clear.
            p_scaled_rem_r1: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (($past(in_s.op) != OP_RSQRT) -> (remainder_o[FRAC_W-1:0] == '0)));
        end
    endgenerate
endmodule

// File: rtl/dsq_pipe.sv
`timescale 1ns/1ps
module dsq_pipe
    import dsq_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int FRAC_W     = 4,
    parameter int RADIX_LOG2 = 1,
    localparam int STAGES    = (DATA_W + FRAC_W + RADIX_LOG2 - 1) / RADIX_LOG2,
    localparam int QW        = STAGES * RADIX_LOG2,
    localparam int IW        = 2 * QW + DATA_W + 2,
    localparam int PW        = 2 + QW + IW + DATA_W,
    localparam int RW        = 2 * DATA_W + 2 * FRAC_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               op_i,
    input  logic [DATA_W+FRAC_W-1:0] dividend_i,
    input  logic [DATA_W-1:0]        operand_i,
    output logic [DATA_W-1:0]        quotient_o,
    output logic [RW-1:0]            remainder_o
);
    logic [PW-1:0] stg [STAGES+1];

    dsq_setup #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .RADIX_LOG2(RADIX_LOG2)) u_setup (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_i       (op_i),
        .dividend_i (dividend_i),
        .operand_i  (operand_i),
        .stg_o      (stg[0])
    );

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_calc
            dsq_calc #(
                .DATA_W(DATA_W), .FRAC_W(FRAC_W), .RADIX_LOG2(RADIX_LOG2), .STAGE(s)
            ) u_calc (
                .clk   (clk),
                .rst_n (rst_n),
                .stg_i (stg[s]),
                .stg_o (stg[s+1])
            );
        end
    endgenerate

    dsq_final #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .RADIX_LOG2(RADIX_LOG2)) u_final (
        .clk         (clk),
        .rst_n       (rst_n),
        .stg_i       (stg[STAGES]),
        .quotient_o  (quotient_o),
        .remainder_o (remainder_o)
    );
endmodule

// File: tb/tb_dsq_pipe.sv
`timescale 1ns/1ps
module tb_dsq_pipe;
    localparam int BW  = 8;
    localparam int FW  = 4;
    localparam int LR  = 1;
    localparam int LAT = (BW + FW + LR - 1) / LR + 2;
    localparam int RW  = 2 * BW + 2 * FW;
    localparam int NV  = 12;

    localparam logic [1:0]    T_OP  [NV] = '{0, 1, 2, 0, 1, 2, 0, 1, 2, 1, 0, 2};
    localparam logic [11:0]   T_N   [NV] = '{100, 4095, 0, 4095, 0, 0, 0, 0, 0, 0, 4095, 0};
    localparam logic [7:0]    T_R   [NV] = '{7, 2, 3, 16, 255, 255, 5, 0, 16, 16, 255, 1};
    localparam logic [7:0]    T_Q   [NV] = '{14, 5, 36, 255, 63, 4, 0, 0, 16, 16, 16, 64};
    localparam logic [RW-1:0] T_REM [NV] = '{32, 112, 208, 240, 1776, 16, 0, 0, 0, 0, 240, 0};
    localparam bit            T_EDGE[NV] = '{0, 0, 0, 1, 1, 1, 1, 1, 0, 0, 0, 1};

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [1:0]     op = '0;
    logic [BW+FW-1:0] dvd = '0;
    logic [BW-1:0]  opd = '0;
    logic [BW-1:0]  quo;
    logic [RW-1:0]  rem;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit             rv [32];
    logic [BW-1:0]  rq [32];
    logic [RW-1:0]  rr [32];
    string          rt [32];

    always #2.5 clk = ~clk;

    dsq_pipe #(.DATA_W(BW), .FRAC_W(FW), .RADIX_LOG2(LR)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_i        (op),
        .dividend_i  (dvd),
        .operand_i   (opd),
        .quotient_o  (quo),
        .remainder_o (rem)
    );

    task automatic check(string tag, logic [BW-1:0] aq, logic [BW-1:0] eq,
                         logic [RW-1:0] ar, logic [RW-1:0] er);
        n_chk++;
        if (aq !== eq || ar !== er) begin
            n_fail++;
            $display("FAIL %s: got quotient %0d remainder %0d, expected quotient %0d remainder %0d",
                     tag, aq, ar, eq, er);
        end
    endtask

    // Drive one input at a falling edge; check the result entered LAT cycles earlier.
    task automatic push(bit v, logic [1:0] o, logic [11:0] n, logic [7:0] r,
                        logic [BW-1:0] eq, logic [RW-1:0] er, string tag);
        @(negedge clk);
        if (cyc >= LAT && rv[(cyc - LAT) % 32])
            check(rt[(cyc - LAT) % 32], quo, rq[(cyc - LAT) % 32], rem, rr[(cyc - LAT) % 32]);
        rv[cyc % 32] = v;
        rq[cyc % 32] = eq;
        rr[cyc % 32] = er;
        rt[cyc % 32] = tag;
        op  = o;
        dvd = n;
        opd = r;
        cyc++;
    endtask

    // Integer reference model taken from the requirement text.
    task automatic ref_calc(int o, int n, int r, output int q, output int rm, output bit ok);
        longint t;
        q = 0; rm = 0; ok = 1'b1;
        if (o == 0) begin
            if (r == 0) ok = 1'b0;
            else begin
                q  = n / r;
                rm = (n % r) << FW;
                ok = (q < (1 << BW));
            end
        end else if (o == 1) begin
            t = longint'(r) << FW;
            while (longint'(q + 1) * (q + 1) <= t) q++;
            rm = int'((t - longint'(q) * q) << FW);
        end else begin
            if (r == 0) ok = 1'b0;
            else begin
                t = longint'(1) << (3 * FW);
                while (longint'(q + 1) * (q + 1) * r <= t) q++;
                rm = int'(t - longint'(q) * q * r);
                ok = (q < (1 << BW));
            end
        end
    endtask

    task automatic push_ref(int o, int n, int r, string tag);
        int q, rm;
        bit ok;
        ref_calc(o, n, r, q, rm, ok);
        if (ok) push(1'b1, 2'(o), 12'(n), 8'(r), BW'(q), RW'(rm), tag);
    endtask

    task automatic flush();
        // Idle divide 0/1 yields zero; checks exact latency of the tail (R4).
        repeat (LAT) push(1'b1, 2'd0, 12'd0, 8'd1, '0, '0, "R4");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R6: outputs stay zero while reset is held, whatever the inputs do.
        op = 2'd1; dvd = 12'hABC; opd = 8'h5A;
        repeat (3) @(negedge clk);
        check("R6", quo, '0, rem, '0);
        rst_n = 1'b1;

        // Directed table, mixed op codes on back-to-back cycles.
        for (int i = 0; i < NV; i++)
            push(1'b1, T_OP[i], T_N[i], T_R[i], T_Q[i], T_REM[i],
                 T_EDGE[i] ? "R7" : (T_OP[i] == 2'd0 ? "R1" : (T_OP[i] == 2'd1 ? "R2" : "R3")));
        flush();

        // R5: square root and reciprocal root interleaved every cycle; R2/R3 sweep.
        for (int r = 0; r < 256; r++) begin
            push_ref(1, (r * 37) % 4096, r, "R5");
            push_ref(2, (r * 91) % 4096, r, "R5");
        end
        flush();

        // R1: divide sweep over every nonzero divisor.
        for (int d = 1; d < 256; d++)
            for (int i = 0; i < 256; i++)
                push_ref(0, (i * 16 + d) % 4096, d, "R1");
        flush();

        // R6: reset in the middle of a stream, then refill.
        for (int i = 0; i < 5; i++) push_ref(2, 0, i + 1, "R3");
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 32; i++) rv[i] = 1'b0;
        @(negedge clk);
        check("R6", quo, '0, rem, '0);
        @(negedge clk);
        check("R6", quo, '0, rem, '0);
        rst_n = 1'b1;
        cyc = 0;
        push_ref(0, 100, 7, "R4");
        flush();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule